// File: doc/BRIEF.md
# SD Card Data FIFO with Threshold Flags

This block is the word buffer between the host's data register and the SD data-line engine. It stores up to sixteen 32-bit words. The host side is a plain register port: a write strobe pushes one word and a read strobe pops one word. The engine side has two valid/ready streams. An inbound stream fills the buffer when data comes from the card. An outbound stream drains it when data goes to the card. Only the stream that matches the active transfer direction is ever enabled.

A transfer is armed with a block size in bytes, a block count and a direction. The block counts words as they leave the buffer and reports the bytes left in the current block and the blocks left. It raises a sticky block flag at the end of each block and returns to idle after the last one. A data-request flag is set from a compare against one of two programmable thresholds: the fill level against the read threshold when data comes from the card, and the free space against the write threshold when data goes to the card. A FIFO error flag records any host access that would overflow or underflow. Every flag is cleared by writing one to its bit. A debug word packs the path state, the fill level and both thresholds. A force input flushes the buffer and drops the transfer.

Back-pressure rules: `eng_in_ready` is high only while a card-to-host transfer is active, the buffer is not full and the host is not writing in that cycle. `eng_out_valid` is high only while a host-to-card transfer is active, the buffer is not empty and the host is not reading in that cycle. A word moves on a stream in any cycle where valid and ready are both high. Host strobes have priority over the engine streams and are never stalled: an illegal host access is dropped and flagged instead.

Top module: `sd_data_fifo`

## Requirements
- R1: `fill_level` equals the number of words stored. `dbg_word` packs the path state in bits 3:0, the fill level in bits 8:4, `thr_wr` in bits 13:9 and `thr_rd` in bits 18:14. All other bits read zero. The path state codes are 0 for idle, 2 for card-to-host (read) and 3 for host-to-card (write).
- R2: Words leave in the order they entered. `host_rdata` and `eng_out_data` both present the oldest stored word.
- R3: A host write when the level is 16 sets status bit 3 and leaves the level and the stored words unchanged.
- R4: A host read when the level is 0 sets status bit 3 and the level stays 0.
- R5: While a read transfer is active, status bit 0 is set one cycle after the fill level is at least `thr_rd`.
- R6: While a write transfer is active, status bit 0 is set one cycle after the free space (16 minus the level) is at least `thr_wr`.
- R7: A one in bit n of `sts_clr` clears status bit n at the next edge, unless the set condition for that bit holds in the same cycle. Status bits other than 0, 3 and 9 always read zero.
- R8: Each word popped during a transfer lowers `bytes_left` by 4. Popping the last word of a block decrements `blocks_left`, reloads `bytes_left` with the block size and sets status bit 9.
- R9: After the last word of the last block is popped, the path returns to idle, `blocks_left` and `bytes_left` read 0, and both engine streams are disabled.
- R10: `xfer_start` is accepted only in idle, with a block size that is a power of two of at least 4 bytes and a nonzero block count. Otherwise it is ignored.
- R11: `force_idle` empties the buffer, returns the path to idle and zeroes both counters at the next edge. It takes priority over any push, pop or start in the same cycle.
- R12: `eng_in_ready` and `eng_out_valid` follow the back-pressure rules stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | DW | Host push word |
| host_rd | input | 1 | Host pop strobe |
| host_rdata | output | DW | Oldest stored word |
| eng_in_valid | input | 1 | Engine inbound word valid |
| eng_in_data | input | DW | Engine inbound word |
| eng_in_ready | output | 1 | Buffer accepts inbound word |
| eng_out_valid | output | 1 | Outbound word available |
| eng_out_data | output | DW | Outbound word |
| eng_out_ready | input | 1 | Engine takes outbound word |
| xfer_start | input | 1 | Arm a transfer |
| xfer_dir_rd | input | 1 | 1 = card-to-host, 0 = host-to-card |
| xfer_blk_bytes | input | BYTE_W | Block size in bytes |
| xfer_blk_num | input | BCNT_W | Number of blocks |
| force_idle | input | 1 | Flush and drop the transfer |
| thr_wr | input | THR_W | Free-space threshold for the write direction |
| thr_rd | input | THR_W | Fill threshold for the read direction |
| sts_clr | input | 10 | Write-one-to-clear mask for the status bits |
| sts | output | 10 | Status: bit 0 data request, bit 3 FIFO error, bit 9 block done |
| dbg_word | output | 32 | Packed state, level and thresholds |
| fill_level | output | LW | Stored word count |
| blocks_left | output | BCNT_W | Blocks remaining |
| bytes_left | output | BYTE_W | Bytes remaining in the current block |

## Verification
The bench targets the threshold boundaries: a level or free space exactly equal to the threshold, one short of it, a threshold of zero and a threshold of sixteen. An off-by-one compare either raises the request one word late or raises it with nothing to move. It drives host accesses into a full and an empty buffer. A design that guards these accesses poorly corrupts the oldest word or wraps the level. The block counter is followed across block boundaries and through the final block. A wrong count either reports no block flag or leaves an engine stream enabled after the transfer ends. The bench also checks that malformed block sizes and a zero block count are refused, and that a flush empties the buffer mid-transfer.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [3:0] {
    XS_IDLE  = 4'h0,
    XS_READ  = 4'h2,
    XS_WRITE = 4'h3
  } xfer_st_e;

  localparam int STS_W    = 10;
  localparam int STS_DATA = 0;
  localparam int STS_FERR = 3;
  localparam int STS_BLK  = 9;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level_q;

  always_ff @(posedge clk) begin
    if (push_en && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push_en) wr_ptr <= wr_ptr + 1'b1;
      if (pop_en)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_en, pop_en})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign level = level_q;
  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_en && !flush) |=> level_q == LW'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_en) |=> level_q == '0); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level_q == '0); // R11
endmodule

// File: rtl/sdf_xfer_count.sv
module sdf_xfer_count
  import sdf_pkg::*;
#(
  parameter int BYTE_W = 12,
  parameter int BCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic              start_rd,
  input  logic [BYTE_W-1:0] blk_bytes,
  input  logic [BCNT_W-1:0] blk_num,
  input  logic              word_pop,
  output xfer_st_e          state,
  output logic [BCNT_W-1:0] blocks_left,
  output logic [BYTE_W-1:0] bytes_left,
  output logic              blk_end
);
  xfer_st_e          st_q;
  logic [BCNT_W-1:0] blk_q;
  logic [BYTE_W-1:0] words_q, wpb_q;
  logic              size_ok, start_ok, active;

  assign size_ok  = (blk_bytes >= BYTE_W'(4)) &&
                    ((blk_bytes & (blk_bytes - 1'b1)) == '0);
  assign start_ok = start && (st_q == XS_IDLE) && size_ok && (blk_num != '0);
  assign active   = (st_q != XS_IDLE);
  assign blk_end  = active && word_pop && (words_q == BYTE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      blk_q   <= '0;
      words_q <= '0;
      wpb_q   <= '0;
    end else if (flush) begin
      st_q    <= XS_IDLE;
      blk_q   <= '0;
      words_q <= '0;
      wpb_q   <= '0;
    end else if (start_ok) begin
      st_q    <= start_rd ? XS_READ : XS_WRITE;
      blk_q   <= blk_num;
      words_q <= blk_bytes >> 2;
      wpb_q   <= blk_bytes >> 2;
    end else if (active && word_pop) begin
      if (blk_end) begin
        blk_q <= blk_q - 1'b1;
        if (blk_q == BCNT_W'(1)) begin
          st_q    <= XS_IDLE;
          words_q <= '0;
        end else begin
          words_q <= wpb_q;
        end
      end else begin
        words_q <= words_q - 1'b1;
      end
    end
  end

  assign state       = st_q;
  assign blocks_left = blk_q;
  assign bytes_left  = {words_q[BYTE_W-3:0], 2'b00};

  AST_BLK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !flush) |=> blk_q == $past(blk_q) - 1'b1); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && blk_q == BCNT_W'(1)) |=> st_q == XS_IDLE); // R9
  AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_IDLE && start && !size_ok) |=> st_q == XS_IDLE); // R10
endmodule

// File: rtl/sdf_status.sv
module sdf_status
  import sdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic [STS_W-1:0] clr_vec,
  output logic [STS_W-1:0] sts
);
  logic [STS_W-1:0] sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_vec) | set_vec;
  end

  assign sts = sts_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[STS_FERR] && !clr_vec[STS_FERR]) |=> sts_q[STS_FERR]); // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[STS_BLK] && !set_vec[STS_BLK]) |=> !sts_q[STS_BLK]); // R7
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sdf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 5,
  parameter int BYTE_W = 12,
  parameter int BCNT_W = 9,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_rd,
  output logic [DW-1:0]     host_rdata,
  input  logic              eng_in_valid,
  input  logic [DW-1:0]     eng_in_data,
  output logic              eng_in_ready,
  output logic              eng_out_valid,
  output logic [DW-1:0]     eng_out_data,
  input  logic              eng_out_ready,
  input  logic              xfer_start,
  input  logic              xfer_dir_rd,
  input  logic [BYTE_W-1:0] xfer_blk_bytes,
  input  logic [BCNT_W-1:0] xfer_blk_num,
  input  logic              force_idle,
  input  logic [THR_W-1:0]  thr_wr,
  input  logic [THR_W-1:0]  thr_rd,
  input  logic [9:0]        sts_clr,
  output logic [9:0]        sts,
  output logic [31:0]       dbg_word,
  output logic [LW-1:0]     fill_level,
  output logic [BCNT_W-1:0] blocks_left,
  output logic [BYTE_W-1:0] bytes_left
);
  localparam int CW = (LW > THR_W ? LW : THR_W) + 1;

  logic          full, empty, push_en, pop_en, blk_end, ferr, data_cond;
  logic [DW-1:0] head, push_data;
  logic [LW-1:0] level;
  logic [CW-1:0] lvl_x, free_x, thr_rd_x, thr_wr_x;
  logic [STS_W-1:0] set_vec;
  xfer_st_e      state;

  assign eng_in_ready  = (state == XS_READ)  && !full  && !host_wr;
  assign eng_out_valid = (state == XS_WRITE) && !empty && !host_rd;
  assign eng_out_data  = head;
  assign host_rdata    = head;

  assign push_en   = (host_wr && !full) || (eng_in_valid && eng_in_ready);
  assign push_data = host_wr ? host_wdata : eng_in_data;
  assign pop_en    = (host_rd && !empty) || (eng_out_valid && eng_out_ready);

  sdf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(force_idle),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .head(head), .level(level), .full(full), .empty(empty)
  );

  sdf_xfer_count #(.BYTE_W(BYTE_W), .BCNT_W(BCNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .flush(force_idle),
    .start(xfer_start), .start_rd(xfer_dir_rd),
    .blk_bytes(xfer_blk_bytes), .blk_num(xfer_blk_num),
    .word_pop(pop_en && !force_idle),
    .state(state), .blocks_left(blocks_left), .bytes_left(bytes_left),
    .blk_end(blk_end)
  );

  assign lvl_x    = CW'(level);
  assign free_x   = CW'(DEPTH) - CW'(level);
  assign thr_rd_x = CW'(thr_rd);
  assign thr_wr_x = CW'(thr_wr);

  assign data_cond = ((state == XS_READ)  && (lvl_x  >= thr_rd_x)) ||
                     ((state == XS_WRITE) && (free_x >= thr_wr_x));
  assign ferr      = (host_wr && full) || (host_rd && empty);

  always_comb begin
    set_vec           = '0;
    set_vec[STS_DATA] = data_cond;
    set_vec[STS_FERR] = ferr;
    set_vec[STS_BLK]  = blk_end;
  end

  sdf_status u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(sts_clr), .sts(sts)
  );

  assign fill_level = level;
  assign dbg_word   = {13'd0, 5'(thr_rd), 5'(thr_wr), 5'(level), state};

  AST_IN_READY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_in_ready |-> (xfer_dir_rd || state == XS_READ) && level < LW'(DEPTH)); // R12
  AST_OUT_VALID_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_out_valid |-> state == XS_WRITE && level != '0); // R12
  AST_ERR_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && full) |=> sts[STS_FERR]); // R3
  AST_ERR_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && empty) |=> sts[STS_FERR]); // R4
endmodule

// File: tb/sd_data_fifo_tb.sv
module sd_data_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        eng_in_valid = 0, eng_in_ready;
  logic [31:0] eng_in_data = 0, eng_out_data;
  logic        eng_out_valid, eng_out_ready = 0;
  logic        xfer_start = 0, xfer_dir_rd = 0, force_idle = 0;
  logic [11:0] xfer_blk_bytes = 0, bytes_left;
  logic [8:0]  xfer_blk_num = 0, blocks_left;
  logic [4:0]  thr_wr = 0, thr_rd = 0, fill_level;
  logic [9:0]  sts_clr = 0, sts;
  logic [31:0] dbg_word;

  int errors = 0, checks = 0, cycles = 0;

  sd_data_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_in_valid(eng_in_valid), .eng_in_data(eng_in_data), .eng_in_ready(eng_in_ready),
    .eng_out_valid(eng_out_valid), .eng_out_data(eng_out_data), .eng_out_ready(eng_out_ready),
    .xfer_start(xfer_start), .xfer_dir_rd(xfer_dir_rd), .xfer_blk_bytes(xfer_blk_bytes),
    .xfer_blk_num(xfer_blk_num), .force_idle(force_idle), .thr_wr(thr_wr), .thr_rd(thr_rd),
    .sts_clr(sts_clr), .sts(sts), .dbg_word(dbg_word), .fill_level(fill_level),
    .blocks_left(blocks_left), .bytes_left(bytes_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {rd_thr, words pushed, expected data flag}; expected level = words pushed
  localparam logic [10:0] VEC [8] = '{
    {5'd4,  5'd3,  1'b0}, {5'd4,  5'd4,  1'b1}, {5'd4, 5'd10, 1'b1},
    {5'd0,  5'd0,  1'b1}, {5'd16, 5'd15, 1'b0}, {5'd16, 5'd16, 1'b1},
    {5'd1,  5'd1,  1'b1}, {5'd8,  5'd7,  1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hwrite(input logic [31:0] d);
    host_wr = 1; host_wdata = d; cyc(1); host_wr = 0;
  endtask

  task automatic hread(output logic [31:0] d);
    d = host_rdata; host_rd = 1; cyc(1); host_rd = 0;
  endtask

  task automatic epush(input logic [31:0] d);
    eng_in_valid = 1; eng_in_data = d; cyc(1); eng_in_valid = 0;
  endtask

  task automatic start(input logic rd, input int bytes, input int blks);
    xfer_dir_rd = rd; xfer_blk_bytes = 12'(bytes); xfer_blk_num = 9'(blks);
    xfer_start = 1; cyc(1); xfer_start = 0;
  endtask

  task automatic flush_clear();
    force_idle = 1; cyc(1); force_idle = 0;
    sts_clr = '1; cyc(1); sts_clr = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    cyc(2); rst_n = 1; cyc(1);
    check("R1 reset level", 32'(fill_level), 0);
    check("R7 reset status", 32'(sts), 0);
    check("R1 reset dbg", dbg_word, 0);

    // R1/R2: level, packing, order
    thr_wr = 5'd4; thr_rd = 5'd4;
    hwrite(32'hA); hwrite(32'hB); hwrite(32'hC);
    check("R1 level 3", 32'(fill_level), 3);
    check("R1 dbg packing", dbg_word, (32'd4 << 14) | (32'd4 << 9) | (32'd3 << 4));
    hread(w); check("R2 order 1", w, 32'hA);
    hread(w); check("R2 order 2", w, 32'hB);
    hread(w); check("R2 order 3", w, 32'hC);

    // R4 underflow, R7 clear
    hread(w);
    check("R4 underflow flag", 32'(sts[3]), 1);
    check("R4 level stays 0", 32'(fill_level), 0);
    sts_clr = 10'h008; cyc(1); sts_clr = 0;
    check("R7 clear error", 32'(sts), 0);

    // R3 overflow keeps contents
    for (int i = 0; i < 16; i++) hwrite(32'(i + 100));
    hwrite(32'hDEAD);
    check("R3 overflow flag", 32'(sts[3]), 1);
    check("R3 level kept", 32'(fill_level), 16);
    check("R3 head kept", host_rdata, 100);
    for (int i = 0; i < 16; i++) hread(w);
    check("R3 last word intact", w, 115);
    flush_clear();

    // R6 write direction, R12, R8/R9
    start(0, 16, 1); cyc(1);
    check("R6 free 16 >= 4 flag", 32'(sts[0]), 1);
    check("R12 no out-valid when empty", 32'(eng_out_valid), 0);
    check("R12 in-ready low in write", 32'(eng_in_ready), 0);
    for (int i = 0; i < 13; i++) hwrite(32'(i + 200));
    sts_clr = 10'h001; cyc(1); sts_clr = 0; cyc(1);
    check("R6 free 3 < 4 no flag", 32'(sts[0]), 0);
    check("R12 out-valid", 32'(eng_out_valid), 1);
    check("R2 out head", eng_out_data, 200);
    eng_out_ready = 1; cyc(4); eng_out_ready = 0;
    check("R9 idle after write", 32'(dbg_word[3:0]), 0);
    check("R8 blk flag", 32'(sts[9]), 1);
    check("R9 out-valid off", 32'(eng_out_valid), 0);
    check("R1 level 9", 32'(fill_level), 9);
    flush_clear();

    // R8 read direction multi-block
    start(1, 8, 3);
    check("R8 state read", 32'(dbg_word[3:0]), 2);
    check("R8 blocks 3", 32'(blocks_left), 3);
    check("R8 bytes 8", 32'(bytes_left), 8);
    for (int i = 0; i < 6; i++) epush(32'(i + 300));
    check("R12 engine push level", 32'(fill_level), 6);
    hread(w);
    check("R8 bytes 4", 32'(bytes_left), 4);
    check("R8 no blk flag yet", 32'(sts[9]), 0);
    hread(w);
    check("R8 blocks 2", 32'(blocks_left), 2);
    check("R8 bytes reload", 32'(bytes_left), 8);
    check("R8 blk flag", 32'(sts[9]), 1);
    for (int i = 0; i < 4; i++) hread(w);
    check("R2 last read word", w, 305);
    check("R9 idle", 32'(dbg_word[3:0]), 0);
    check("R9 blocks 0", 32'(blocks_left), 0);
    check("R9 bytes 0", 32'(bytes_left), 0);
    check("R9 in-ready off", 32'(eng_in_ready), 0);
    flush_clear();

    // R10 start validity
    start(1, 12, 2); check("R10 size 12 rejected", 32'(dbg_word[3:0]), 0);
    start(1, 2, 2);  check("R10 size 2 rejected", 32'(dbg_word[3:0]), 0);
    start(1, 4, 0);  check("R10 zero blocks rejected", 32'(dbg_word[3:0]), 0);
    start(1, 4, 1);  check("R10 size 4 accepted", 32'(dbg_word[3:0]), 2);

    // R11 force flush
    for (int i = 0; i < 5; i++) epush(32'(i));
    force_idle = 1; cyc(1); force_idle = 0;
    check("R11 level 0", 32'(fill_level), 0);
    check("R11 idle", 32'(dbg_word[3:0]), 0);
    check("R11 blocks 0", 32'(blocks_left), 0);

    // R5 threshold table
    for (int v = 0; v < 8; v++) begin
      flush_clear();
      thr_rd = VEC[v][10:6];
      start(1, 64, 4);
      for (int i = 0; i < int'(VEC[v][5:1]); i++) epush(32'(i));
      cyc(2);
      check($sformatf("R5 vec %0d level", v), 32'(fill_level), 32'(VEC[v][5:1]));
      check($sformatf("R5 vec %0d flag", v), 32'(sts[0]), 32'(VEC[v][0]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule